// File: doc/BRIEF.md
# SPI Command Queue and Status Unit

This unit is the host-facing front end of an SPI master. Software writes 32-bit push words into a four-entry transmit queue. The upper half of each word is a per-frame command: hold chip select, attribute-set select, end-of-queue, counter clear and a one-hot chip-select mask. The lower half is the frame data. The unit presents the oldest entry to a separate shift engine. When the engine reports that the frame has finished, the unit retires the entry and stores the received frame in a four-entry receive queue. Software removes received frames by reading a pop register.

Each completed frame updates a 16-bit transfer counter and a set of status flags. The per-frame command bits decide what happens: a frame carrying the counter-clear bit resets the counter instead of advancing it. A frame carrying the end-of-queue bit raises a flag and freezes the queue until software clears that flag. The flags, masked by an interrupt enable register, drive one interrupt line.

A sequencer with three states controls issue. In `SEQ_IDLE` the transmit queue is empty. In `SEQ_ISSUE` an entry is offered to the engine. In `SEQ_HALT` an end-of-queue frame has finished and issue is frozen. The transitions are:

- *fill*: IDLE to ISSUE when the queue will be non-empty.
- *drain*: ISSUE to IDLE when the queue will be empty.
- *stop*: ISSUE to HALT when an end-of-queue frame completes.
- *release*: HALT to ISSUE or IDLE when software clears the end-of-queue flag.

Top module: `spi_cmdq_unit`

## Requirements
- R1: A push word (write select 4) carries the command in bits 31:16 and the data in bits 15:0. The transmit queue holds 4 entries. A push while the queue is full is dropped, unless a frame completes in the same cycle. While an entry is offered, `eng_cmd` and `eng_data` show the oldest entry's halves; otherwise both read 0.
- R2: `eng_req` is high exactly when the transmit queue is non-empty and the unit is not halted. A frame completes when `eng_done` is high while `eng_req` is high. `eng_done` has no effect at any other time.
- R3: The transfer counter reads in bits 31:16 of select 1, and bits 15:0 read 0. It advances by one per completed frame. It becomes 0 instead when the completing frame has command bit 10 (word bit 26) set.
- R4: Status bit 31 (select 2) sets when a frame completes. It stays set until a write of 1 to bit 31 at select 2. A completion in the same cycle as that write wins.
- R5: A frame with command bit 11 (word bit 27) set raises status bit 28 when it completes, and stops all issue. Writing 1 to status bit 28 clears the flag and resumes issue.
- R6: Status bit 25 reads 1 while the transmit queue is not full. Status bit 17 reads 1 while the receive queue is not empty. Both follow the queues directly.
- R7: The receive queue holds 4 entries and takes `eng_rx` on each completion. A read with `rd_en` at select 5 returns the oldest frame in bits 15:0 and removes it. A pop from an empty queue returns 0 and changes nothing.
- R8: When a frame completes while the receive queue is full and no pop happens in the same cycle, the frame is discarded and status bit 19 sets. Bit 19 is sticky and is cleared by writing 1 to it.
- R9: A write to select 0 with bit 11 set empties the transmit queue. Bit 10 set empties the receive queue. Select 0 reads 0.
- R10: The interrupt enable register (select 3) keeps only bits 31, 28, 25 and 17; all other bits read 0. `irq` is high while any status bit among these is set and its enable bit is also set.
- R11: After reset both queues are empty, the counter and the sticky flags are 0, the enables are 0, `eng_req` and `irq` are low, and status reads 0x0200_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write select: 0 control, 2 status, 3 enable, 4 push |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; removes an entry at select 5 |
| rd_sel | input | 3 | Read select: 0 control, 1 counter, 2 status, 3 enable, 5 pop |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| eng_req | output | 1 | An entry is offered to the shift engine |
| eng_cmd | output | 16 | Command half of the offered entry |
| eng_data | output | 16 | Data half of the offered entry |
| eng_done | input | 1 | The shift engine finished the offered frame |
| eng_rx | input | 16 | Frame received during that frame |
| irq | output | 1 | Interrupt request |

## Verification
A write, a pop or a completion presented in one cycle takes effect at the next rising edge. The new queue, counter, flag and `eng_req`/`eng_cmd` values are therefore due one cycle later. `rd_data` and `irq` are combinational from that registered state, so they are due in the same cycle as the state. The bench drives inputs on the falling edge and compares every output 1 ns later against a queue-based model. It then lets the model absorb that cycle's inputs at the rising edge. Every result is thus compared exactly one edge after its cause and is never sampled at the edge itself.

// File: rtl/spi_cmdq_pkg.sv
package spi_cmdq_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_HALT  = 2'd2
    } seq_state_t;

    // register selects
    localparam logic [2:0] SEL_CTRL  = 3'd0;
    localparam logic [2:0] SEL_COUNT = 3'd1;
    localparam logic [2:0] SEL_STAT  = 3'd2;
    localparam logic [2:0] SEL_IEN   = 3'd3;
    localparam logic [2:0] SEL_PUSH  = 3'd4;
    localparam logic [2:0] SEL_POP   = 3'd5;

    // command half bit positions
    localparam int CMD_EOQ   = 11;
    localparam int CMD_CTCLR = 10;

    // status bit positions
    localparam int ST_DONE = 31;
    localparam int ST_EOQ  = 28;
    localparam int ST_TXNF = 25;
    localparam int ST_OVF  = 19;
    localparam int ST_RXNE = 17;

    // control bit positions
    localparam int CTL_CLRTX = 11;
    localparam int CTL_CLRRX = 10;

    localparam logic [31:0] IEN_MASK = 32'h9202_0000;

endpackage

// File: rtl/spi_cmdq_fifo.sv
module spi_cmdq_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             push,
    input  logic [WIDTH-1:0]                 push_data,
    input  logic                             pop,
    output logic [WIDTH-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]       level,
    output logic                             accepted
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rptr, wptr;
    logic             pop_ok, full, empty;

    assign full     = (level == LVL_W'(DEPTH));
    assign empty    = (level == '0);
    assign pop_ok   = pop && !empty;
    assign accepted = push && (!full || pop_ok);
    assign head     = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (accepted) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else if (clr) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else begin
            if (accepted) wptr <= bump(wptr);
            if (pop_ok)   rptr <= bump(rptr);
            level <= level + LVL_W'(accepted) - LVL_W'(pop_ok);
        end
    end
endmodule

// File: rtl/spi_cmdq_seq.sv
module spi_cmdq_seq
    import spi_cmdq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fill_next,
    input  logic frame_fire,
    input  logic frame_eoq,
    input  logic eoq_release,
    output logic issue,
    output logic halted
);
    seq_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  state_nx = fill_next ? SEQ_ISSUE : SEQ_IDLE;
            SEQ_ISSUE: begin
                if (frame_fire && frame_eoq) state_nx = SEQ_HALT;
                else if (!fill_next)         state_nx = SEQ_IDLE;
            end
            SEQ_HALT: begin
                if (eoq_release) state_nx = fill_next ? SEQ_ISSUE : SEQ_IDLE;
            end
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        issue  = (state == SEQ_ISSUE);
        halted = (state == SEQ_HALT);
    end
endmodule

// File: rtl/spi_cmdq_stat.sv
module spi_cmdq_stat
    import spi_cmdq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_fire,
    input  logic                frame_clr_cnt,
    input  logic                rx_drop,
    input  logic                w1c_done,
    input  logic                w1c_ovf,
    input  logic                ien_we,
    input  logic [WORD_W-1:0]   ien_wdata,
    input  logic                halted,
    input  logic                tx_full,
    input  logic                rx_empty,
    output logic [HALF_W-1:0]   xfer_cnt,
    output logic [WORD_W-1:0]   status,
    output logic [WORD_W-1:0]   ien,
    output logic                irq
);
    logic done_q, ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_cnt <= '0;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
            ien      <= '0;
        end else begin
            if (frame_fire)
                xfer_cnt <= frame_clr_cnt ? '0 : xfer_cnt + HALF_W'(1);
            if (frame_fire)    done_q <= 1'b1;
            else if (w1c_done) done_q <= 1'b0;
            if (rx_drop)       ovf_q  <= 1'b1;
            else if (w1c_ovf)  ovf_q  <= 1'b0;
            if (ien_we)        ien    <= ien_wdata & IEN_MASK;
        end
    end

    always_comb begin
        status          = '0;
        status[ST_DONE] = done_q;
        status[ST_EOQ]  = halted;
        status[ST_TXNF] = !tx_full;
        status[ST_OVF]  = ovf_q;
        status[ST_RXNE] = !rx_empty;
        irq             = |(status & ien);
    end
endmodule

// File: rtl/spi_cmdq_unit.sv
module spi_cmdq_unit
    import spi_cmdq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic              eng_req,
    output logic [15:0]       eng_cmd,
    output logic [15:0]       eng_data,
    input  logic              eng_done,
    input  logic [15:0]       eng_rx,
    output logic              irq
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    logic              wr_push, wr_ctrl, wr_stat, wr_ien, rd_pop;
    logic              clr_tx, clr_rx, frame_fire, halted, issue;
    logic [WORD_W-1:0] tx_head;
    logic [HALF_W-1:0] rx_head, xfer_cnt;
    logic [LVL_W-1:0]  tx_level, rx_level, tx_level_nx;
    logic              tx_acc, rx_acc, tx_full, rx_empty;
    logic [WORD_W-1:0] stat_word, ien_word;

    always_comb begin
        wr_push = wr_en && (wr_sel == SEL_PUSH);
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
        wr_stat = wr_en && (wr_sel == SEL_STAT);
        wr_ien  = wr_en && (wr_sel == SEL_IEN);
        rd_pop  = rd_en && (rd_sel == SEL_POP);
        clr_tx  = wr_ctrl && wr_data[CTL_CLRTX];
        clr_rx  = wr_ctrl && wr_data[CTL_CLRRX];
    end

    assign eng_req    = issue;
    assign frame_fire = issue && eng_done;
    assign tx_full    = (tx_level == LVL_W'(FIFO_DEPTH));
    assign rx_empty   = (rx_level == '0);

    spi_cmdq_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) tx_q (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx),
        .push(wr_push), .push_data(wr_data), .pop(frame_fire),
        .head(tx_head), .level(tx_level), .accepted(tx_acc)
    );

    spi_cmdq_fifo #(.WIDTH(HALF_W), .DEPTH(FIFO_DEPTH)) rx_q (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx),
        .push(frame_fire), .push_data(eng_rx), .pop(rd_pop),
        .head(rx_head), .level(rx_level), .accepted(rx_acc)
    );

    always_comb begin
        tx_level_nx = tx_level;
        if (clr_tx) tx_level_nx = '0;
        else begin
            if (tx_acc)     tx_level_nx = tx_level_nx + LVL_W'(1);
            if (frame_fire) tx_level_nx = tx_level_nx - LVL_W'(1);
        end
    end

    spi_cmdq_seq seq_i (
        .clk(clk), .rst_n(rst_n),
        .fill_next(tx_level_nx != '0),
        .frame_fire(frame_fire),
        .frame_eoq(tx_head[HALF_W + CMD_EOQ]),
        .eoq_release(wr_stat && wr_data[ST_EOQ]),
        .issue(issue), .halted(halted)
    );

    spi_cmdq_stat stat_i (
        .clk(clk), .rst_n(rst_n),
        .frame_fire(frame_fire),
        .frame_clr_cnt(tx_head[HALF_W + CMD_CTCLR]),
        .rx_drop(frame_fire && !rx_acc),
        .w1c_done(wr_stat && wr_data[ST_DONE]),
        .w1c_ovf(wr_stat && wr_data[ST_OVF]),
        .ien_we(wr_ien), .ien_wdata(wr_data),
        .halted(halted), .tx_full(tx_full), .rx_empty(rx_empty),
        .xfer_cnt(xfer_cnt), .status(stat_word), .ien(ien_word), .irq(irq)
    );

    assign eng_cmd  = issue ? tx_head[WORD_W-1:HALF_W] : '0;
    assign eng_data = issue ? tx_head[HALF_W-1:0]      : '0;

    always_comb begin
        unique case (rd_sel)
            SEL_COUNT: rd_data = {xfer_cnt, 16'h0000};
            SEL_STAT:  rd_data = stat_word;
            SEL_IEN:   rd_data = ien_word;
            SEL_POP:   rd_data = rx_empty ? '0 : {16'h0000, rx_head};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/spi_cmdq_chk.sv
module spi_cmdq_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       eng_req,
    input logic                       eng_done,
    input logic                       cmd_clr,
    input logic                       cmd_eoq,
    input logic                       halted,
    input logic [15:0]                xfer_cnt,
    input logic                       done_flag,
    input logic                       ovf_flag,
    input logic [$clog2(DEPTH+1)-1:0] tx_level,
    input logic [$clog2(DEPTH+1)-1:0] rx_level
);
    // R2
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !eng_req);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && !cmd_clr) |=> xfer_cnt == $past(xfer_cnt) + 16'd1);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && cmd_clr) |=> xfer_cnt == 16'd0);

    // R4
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> done_flag);

    // R5
    eoq_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done && cmd_eoq) |=> (halted && !eng_req));

    // R8
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(eng_req && eng_done));

    // R1
    tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= ($clog2(DEPTH+1))'(DEPTH));

    // R7
    rx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= ($clog2(DEPTH+1))'(DEPTH));
endmodule

bind spi_cmdq_unit spi_cmdq_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .eng_req(eng_req), .eng_done(eng_done),
    .cmd_clr(eng_cmd[10]), .cmd_eoq(eng_cmd[11]),
    .halted(halted), .xfer_cnt(xfer_cnt),
    .done_flag(stat_word[31]), .ovf_flag(stat_word[19]),
    .tx_level(tx_level), .rx_level(rx_level)
);

// File: tb/spi_cmdq_unit_tb_top.sv
`timescale 1ns/1ps
module spi_cmdq_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en, eng_done;
    logic [2:0]  wr_sel, rd_sel;
    logic [31:0] wr_data, rd_data;
    logic        eng_req, irq;
    logic [15:0] eng_cmd, eng_data, eng_rx;

    always #2.5 clk = ~clk;

    spi_cmdq_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_data(eng_data),
        .eng_done(eng_done), .eng_rx(eng_rx), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] txq[$];
    logic [15:0] rxq[$];
    logic [15:0] m_cnt = '0;
    bit          m_done = 0, m_ovf = 0, m_halt = 0;
    logic [31:0] m_ien = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        s[31] = m_done;
        s[28] = m_halt;
        s[25] = (txq.size() < 4);
        s[19] = m_ovf;
        s[17] = (rxq.size() > 0);
        return s;
    endfunction

    function automatic logic [31:0] exp_read(input logic [2:0] s);
        case (s)
            3'd1: return {m_cnt, 16'h0};
            3'd2: return exp_status();
            3'd3: return m_ien;
            3'd5: return (rxq.size() > 0) ? {16'h0, rxq[0]} : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [2:0] s);
        case (s)
            3'd0: return "R9 control reads 0";
            3'd1: return "R3 counter";
            3'd2: return "R4 R5 R6 R8 status";
            3'd3: return "R10 enable";
            3'd5: return "R7 pop data";
            default: return "R1 unused select reads 0";
        endcase
    endfunction

    // one clock: drive, compare, then let the model absorb the inputs
    task automatic cyc(input bit we, input logic [2:0] sel, input logic [31:0] data,
                       input bit re, input logic [2:0] rsel, input bit dn, input logic [15:0] rx);
        bit issue, fire, popr, ovf_set, w1c;
        logic [31:0] head;
        @(negedge clk);
        wr_en = we; wr_sel = sel; wr_data = data;
        rd_en = re; rd_sel = rsel; eng_done = dn; eng_rx = rx;
        #1;
        issue = !m_halt && (txq.size() > 0);
        check("R2 eng_req", {31'b0, eng_req}, {31'b0, issue});
        check("R1 eng_cmd", {16'h0, eng_cmd}, issue ? {16'h0, txq[0][31:16]} : 32'h0);
        check("R1 eng_data", {16'h0, eng_data}, issue ? {16'h0, txq[0][15:0]} : 32'h0);
        check("R10 irq", {31'b0, irq}, {31'b0, |(exp_status() & m_ien)});
        check(read_tag(rsel), rd_data, exp_read(rsel));
        @(posedge clk);
        fire = dn && issue;
        popr = re && (rsel == 3'd5) && (rxq.size() > 0);
        ovf_set = 0;
        head = '0;
        if (popr) void'(rxq.pop_front());
        if (fire) begin
            head = txq.pop_front();
            m_cnt = head[26] ? 16'h0 : m_cnt + 16'h1;
            if (rxq.size() < 4) rxq.push_back(rx);
            else ovf_set = 1;
        end
        if (we && sel == 3'd4 && txq.size() < 4) txq.push_back(data);
        if (we && sel == 3'd0) begin
            if (data[11]) txq.delete();
            if (data[10]) rxq.delete();
        end
        w1c = we && (sel == 3'd2);
        if (fire) m_done = 1; else if (w1c && data[31]) m_done = 0;
        if (ovf_set) m_ovf = 1; else if (w1c && data[19]) m_ovf = 0;
        if (m_halt) begin
            if (w1c && data[28]) m_halt = 0;
        end else if (fire && head[27]) m_halt = 1;
        if (we && sel == 3'd3) m_ien = data & 32'h9202_0000;
    endtask

    task automatic idle(input logic [2:0] rsel);
        cyc(0, 3'd0, 32'h0, 0, rsel, 0, 16'h0);
    endtask
    task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic [2:0] rsel);
        cyc(1, sel, d, 0, rsel, 0, 16'h0);
    endtask
    task automatic fin(input logic [15:0] rx, input logic [2:0] rsel);
        cyc(0, 3'd0, 32'h0, 0, rsel, 1, rx);
    endtask
    task automatic pop();
        cyc(0, 3'd0, 32'h0, 1, 3'd5, 0, 16'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
        rd_en = 0; rd_sel = 0; eng_done = 0; eng_rx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        rd_sel = 3'd2; #1;
        // R11 reset state
        check("R11 status after reset", rd_data, 32'h0200_0000);
        check("R11 eng_req after reset", {31'b0, eng_req}, 32'h0);
        check("R11 irq after reset", {31'b0, irq}, 32'h0);
        for (int s = 0; s < 8; s++) idle(3'(s));

        // R10 enables
        wr(3'd3, 32'hFFFF_FFFF, 3'd3);
        idle(3'd3);
        wr(3'd3, 32'h8000_0000, 3'd3);
        idle(3'd2);

        // R1 fill the queue; fifth push dropped
        wr(3'd4, 32'h8001_00A1, 3'd2);
        wr(3'd4, 32'h0402_00B2, 3'd2);
        wr(3'd4, 32'h0804_00C3, 3'd2);
        wr(3'd4, 32'h0001_00D4, 3'd2);
        wr(3'd4, 32'h0020_00E5, 3'd2);
        idle(3'd2);

        // R3 counter step and clear, R5 halt on end of queue
        fin(16'h1111, 3'd1);
        fin(16'h2222, 3'd1);
        fin(16'h3333, 3'd2);
        fin(16'h4444, 3'd2);  // R2 ignored while halted
        idle(3'd1);
        wr(3'd2, 32'h1000_0000, 3'd2);  // R5 release
        fin(16'h5555, 3'd1);
        idle(3'd2);

        // R8 overflow, then completion with same-cycle pop is kept
        wr(3'd4, 32'h0001_0101, 3'd2);
        wr(3'd4, 32'h0001_0202, 3'd2);
        fin(16'h6666, 3'd2);
        cyc(0, 3'd0, 32'h0, 1, 3'd5, 1, 16'h7777);
        idle(3'd2);

        // R7 pops including empty pops
        for (int i = 0; i < 6; i++) pop();
        idle(3'd2);

        // R4 R8 write-one-to-clear
        wr(3'd2, 32'h8008_0000, 3'd2);
        idle(3'd2);

        // R9 flush TX
        wr(3'd4, 32'h0001_0011, 3'd2);
        wr(3'd4, 32'h0001_0022, 3'd2);
        wr(3'd0, 32'h0000_0800, 3'd2);
        idle(3'd2);
        fin(16'h9999, 3'd5);  // R2 done with nothing offered
        idle(3'd5);

        // R9 flush RX, R10 irq on RX not empty
        wr(3'd3, 32'h0002_0000, 3'd3);
        wr(3'd4, 32'h0401_0033, 3'd2);
        fin(16'hABCD, 3'd5);
        idle(3'd5);
        wr(3'd0, 32'h0000_0400, 3'd5);
        idle(3'd5);

        // R1 push into empty queue with done in the same cycle
        cyc(1, 3'd4, 32'h0001_0044, 0, 3'd1, 1, 16'h1234);
        idle(3'd1);
        fin(16'h4321, 3'd5);
        idle(3'd5);

        // R1 push while full accepted when a frame completes together
        wr(3'd4, 32'h0001_0051, 3'd2);
        wr(3'd4, 32'h0001_0052, 3'd2);
        wr(3'd4, 32'h0001_0053, 3'd2);
        wr(3'd4, 32'h0001_0054, 3'd2);
        cyc(1, 3'd4, 32'h0001_0055, 0, 3'd2, 1, 16'h0F0F);
        idle(3'd2);
        for (int i = 0; i < 5; i++) fin(16'(16'h0100 + i), 3'd1);
        wr(3'd3, 32'hFFFF_FFFF, 3'd3);
        for (int s = 0; s < 8; s++) idle(3'(s));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule